// File: doc/BRIEF.md
# Priority-Locked Error Capture Unit

This unit keeps a single record of one hardware error event: the address at which the error was seen, a 4-bit tag syndrome and a 9-bit data syndrome. Each error source has its own status bit index. Each reported event carries a priority class. Many status bits may be pending at once, but only one event owns the record. The record goes to the highest-priority event. A later event of a strictly higher class takes the record over. A later event of the same or a lower class leaves the first capture in place.

The record is locked to the status bit of its owner. When software writes that status register with a clear mask, a set mask bit at the owner's index unlocks the record. This holds even if other status bits remain set. After unlocking, the record keeps its contents until the next event is captured. The status bits themselves are kept elsewhere. The unit only watches the clear-write mask.

Control is a three-state machine:
- ST_EMPTY: nothing has been captured since reset.
- ST_HELD: the record is locked.
- ST_FREE: the record is unlocked and its old contents are retained.

The transitions are:
- T_FIRST: ST_EMPTY to ST_HELD, on any event.
- T_PROMOTE: ST_HELD to ST_HELD, when a strictly higher class overwrites the record.
- T_RELEASE: ST_HELD to ST_FREE, when the owner's bit is cleared and no event arrives.
- T_SWAP: ST_HELD to ST_HELD, when the owner's bit is cleared and a new event arrives in the same cycle.
- T_RECAPTURE: ST_FREE to ST_HELD, on any event.

Top module: `errcap_unit`

## Requirements
- R1: While reset is active and after it is released, cap_valid, cap_idx, cap_cls, cap_addr and cap_syn are all zero.
- R2: When no record is locked, any event makes the winning event's index, class, err_addr and syndromes appear on the outputs on the next clock edge, with cap_valid high.
- R3: Among events in the same cycle, the highest class wins. Class codes are 3 uncorrectable, 2 software-correctable, 1 hardware-corrected and 0 informational, and class i of the event on err_vld[i] sits in err_cls[2*i+1:2*i]. Ties within a class go to the lowest index.
- R4: While locked, a winning event of a strictly higher class than cap_cls overwrites every captured field on the next edge.
- R5: While locked, events whose class is equal to or lower than cap_cls change no output.
- R6: A clear write (clr_we high) whose clr_mask bit at cap_idx is set drops cap_valid on the next edge. A clear write with that bit zero changes no output.
- R7: While unlocked, cap_idx, cap_cls, cap_addr and cap_syn keep their values until a new event is captured.
- R8: If the owner's bit is cleared in the same cycle as events arrive, the winner of that cycle is captured whatever its class, and cap_valid stays high.
- R9: cap_syn carries the tag syndrome at bits 19:16 and the data syndrome at bits 8:0. Bits 15:9 are zero.
- R10: clr_mask has no effect while clr_we is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| err_vld | input | N | One event flag per status bit index |
| err_cls | input | 2*N | Class of each event, two bits per index |
| err_addr | input | ADDR_W | Fault address reported this cycle |
| err_tsyn | input | 4 | Tag syndrome reported this cycle |
| err_dsyn | input | 9 | Data syndrome reported this cycle |
| clr_we | input | 1 | Write strobe of the status clear |
| clr_mask | input | N | Write-one-to-clear mask |
| cap_valid | output | 1 | Record is locked |
| cap_idx | output | log2(N) | Status bit index of the owner |
| cap_cls | output | 2 | Class of the owner |
| cap_addr | output | ADDR_W | Captured address |
| cap_syn | output | 20 | Captured syndromes, packed |

## Verification
Two functions can fall in the same cycle: the clear of the owner's status bit, and the arrival of new events. The owner-clear might then be dropped, or the new event might be lost to the release. The stimulus provokes this overlap in two ways. Random clears often aim at the current owner while events are being injected. A directed step also clears the owner together with an event of the lowest class. In each such cycle, the bench model releases the record first and then captures the winner. It expects cap_valid to stay high with the new event's fields, and every output is compared against that expectation one edge later.

// File: rtl/errcap_pkg.sv
package errcap_pkg;

    // Packed syndrome word layout
    localparam int TSYN_W     = 4;
    localparam int DSYN_W     = 9;
    localparam int TSYN_LSB   = 16;
    localparam int DSYN_LSB   = 0;
    localparam int SYN_WORD_W = TSYN_LSB + TSYN_W;

    // Priority classes: higher code means higher priority
    localparam int CLS_W    = 2;
    localparam int NUM_CLS  = 1 << CLS_W;

    typedef logic [CLS_W-1:0] cls_t;

    typedef enum logic [1:0] {
        ST_EMPTY = 2'd0,
        ST_HELD  = 2'd1,
        ST_FREE  = 2'd2
    } lock_st_e;

endpackage

// File: rtl/errcap_arbiter.sv
module errcap_arbiter
    import errcap_pkg::*;
#(
    parameter int N     = 16,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]       vld,
    input  logic [CLS_W*N-1:0] cls,
    output logic               win_any,
    output logic [IDX_W-1:0]   win_idx,
    output cls_t               win_cls
);

    logic [N-1:0]     req [NUM_CLS];
    logic [IDX_W-1:0] enc [NUM_CLS];

    function automatic logic [IDX_W-1:0] lowest_set(input logic [N-1:0] v);
        logic [IDX_W-1:0] r;
        r = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (v[i]) r = IDX_W'(i);
        end
        return r;
    endfunction

    // One request vector and one lowest-index encoder per class
    for (genvar c = 0; c < NUM_CLS; c++) begin : g_cls
        for (genvar i = 0; i < N; i++) begin : g_bit
            assign req[c][i] = vld[i] && (cls[CLS_W*i +: CLS_W] == CLS_W'(c));
        end
        assign enc[c] = lowest_set(req[c]);
    end

    // Highest class with a request wins
    always_comb begin
        win_any = 1'b0;
        win_idx = '0;
        win_cls = '0;
        for (int c = 0; c < NUM_CLS; c++) begin
            if (|req[c]) begin
                win_any = 1'b1;
                win_idx = enc[c];
                win_cls = CLS_W'(c);
            end
        end
    end

endmodule

// File: rtl/errcap_lock_fsm.sv
module errcap_lock_fsm
    import errcap_pkg::*;
#(
    parameter int N     = 16,
    parameter int IDX_W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             win_any,
    input  cls_t             win_cls,
    input  logic             clr_we,
    input  logic [N-1:0]     clr_mask,
    input  logic [IDX_W-1:0] held_idx,
    input  cls_t             held_cls,
    output logic             load,
    output logic             held
);

    lock_st_e st_q, st_d;
    logic     own_clr;

    assign own_clr = clr_we && clr_mask[held_idx];

    // Next state and load decision
    always_comb begin
        st_d = st_q;
        load = 1'b0;
        unique case (st_q)
            ST_EMPTY: begin
                if (win_any) begin          // T_FIRST
                    load = 1'b1;
                    st_d = ST_HELD;
                end
            end
            ST_HELD: begin
                if (own_clr) begin
                    if (win_any) begin      // T_SWAP
                        load = 1'b1;
                        st_d = ST_HELD;
                    end else begin          // T_RELEASE
                        st_d = ST_FREE;
                    end
                end else if (win_any && (win_cls > held_cls)) begin
                    load = 1'b1;            // T_PROMOTE
                    st_d = ST_HELD;
                end
            end
            ST_FREE: begin
                if (win_any) begin          // T_RECAPTURE
                    load = 1'b1;
                    st_d = ST_HELD;
                end
            end
            default: st_d = ST_EMPTY;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_EMPTY;
        else        st_q <= st_d;
    end

    // Outputs
    always_comb begin
        held = (st_q == ST_HELD);
    end

endmodule

// File: rtl/errcap_store.sv
module errcap_store
    import errcap_pkg::*;
#(
    parameter int ADDR_W = 40,
    parameter int IDX_W  = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load,
    input  logic [IDX_W-1:0]      in_idx,
    input  cls_t                  in_cls,
    input  logic [ADDR_W-1:0]     in_addr,
    input  logic [TSYN_W-1:0]     in_tsyn,
    input  logic [DSYN_W-1:0]     in_dsyn,
    output logic [IDX_W-1:0]      q_idx,
    output cls_t                  q_cls,
    output logic [ADDR_W-1:0]     q_addr,
    output logic [SYN_WORD_W-1:0] q_syn
);

    logic [TSYN_W-1:0] tsyn_q;
    logic [DSYN_W-1:0] dsyn_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_idx  <= '0;
            q_cls  <= '0;
            q_addr <= '0;
            tsyn_q <= '0;
            dsyn_q <= '0;
        end else if (load) begin
            q_idx  <= in_idx;
            q_cls  <= in_cls;
            q_addr <= in_addr;
            tsyn_q <= in_tsyn;
            dsyn_q <= in_dsyn;
        end
    end

    always_comb begin
        q_syn = '0;
        q_syn[TSYN_LSB +: TSYN_W] = tsyn_q;
        q_syn[DSYN_LSB +: DSYN_W] = dsyn_q;
    end

endmodule

// File: rtl/errcap_unit.sv
module errcap_unit
    import errcap_pkg::*;
#(
    parameter int N      = 16,
    parameter int ADDR_W = 40,
    parameter int IDX_W  = $clog2(N)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [N-1:0]          err_vld,
    input  logic [CLS_W*N-1:0]    err_cls,
    input  logic [ADDR_W-1:0]     err_addr,
    input  logic [TSYN_W-1:0]     err_tsyn,
    input  logic [DSYN_W-1:0]     err_dsyn,
    input  logic                  clr_we,
    input  logic [N-1:0]          clr_mask,
    output logic                  cap_valid,
    output logic [IDX_W-1:0]      cap_idx,
    output logic [CLS_W-1:0]      cap_cls,
    output logic [ADDR_W-1:0]     cap_addr,
    output logic [SYN_WORD_W-1:0] cap_syn
);

    logic             win_any;
    logic [IDX_W-1:0] win_idx;
    cls_t             win_cls;
    logic             load;

    errcap_arbiter #(.N(N), .IDX_W(IDX_W)) u_arb (
        .vld     (err_vld),
        .cls     (err_cls),
        .win_any (win_any),
        .win_idx (win_idx),
        .win_cls (win_cls)
    );

    errcap_lock_fsm #(.N(N), .IDX_W(IDX_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .win_any  (win_any),
        .win_cls  (win_cls),
        .clr_we   (clr_we),
        .clr_mask (clr_mask),
        .held_idx (cap_idx),
        .held_cls (cap_cls),
        .load     (load),
        .held     (cap_valid)
    );

    errcap_store #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .in_idx  (win_idx),
        .in_cls  (win_cls),
        .in_addr (err_addr),
        .in_tsyn (err_tsyn),
        .in_dsyn (err_dsyn),
        .q_idx   (cap_idx),
        .q_cls   (cap_cls),
        .q_addr  (cap_addr),
        .q_syn   (cap_syn)
    );

endmodule

// File: rtl/errcap_chk.sv
module errcap_chk
    import errcap_pkg::*;
#(
    parameter int N      = 16,
    parameter int ADDR_W = 40,
    parameter int IDX_W  = $clog2(N)
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [N-1:0]          err_vld,
    input logic [CLS_W*N-1:0]    err_cls,
    input logic                  clr_we,
    input logic [N-1:0]          clr_mask,
    input logic                  cap_valid,
    input logic [IDX_W-1:0]      cap_idx,
    input logic [CLS_W-1:0]      cap_cls,
    input logic [ADDR_W-1:0]     cap_addr,
    input logic [SYN_WORD_W-1:0] cap_syn
);

    logic owner_hit;
    logic higher;

    assign owner_hit = clr_we && clr_mask[cap_idx];

    always_comb begin
        higher = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (err_vld[i] && (err_cls[CLS_W*i +: CLS_W] > cap_cls)) higher = 1'b1;
        end
    end

    AST_FIRST_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (!cap_valid && (|err_vld)) |=> cap_valid);                              // R2

    AST_PROMOTE_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_valid && !owner_hit && higher) |=> (cap_valid && (cap_cls > $past(cap_cls)))); // R4

    AST_SAME_CLASS_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_valid && !owner_hit && !higher) |=>
            (cap_valid && $stable(cap_idx) && $stable(cap_addr) && $stable(cap_syn))); // R5

    AST_OWNER_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_valid && owner_hit && !(|err_vld)) |=> !cap_valid);                // R6

    AST_FREE_RETAINS: assert property (@(posedge clk) disable iff (!rst_n)
        (!cap_valid && !(|err_vld)) |=>
            ($stable(cap_idx) && $stable(cap_cls) && $stable(cap_addr) && $stable(cap_syn))); // R7

    AST_SWAP_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_valid && owner_hit && (|err_vld)) |=> cap_valid);                  // R8

endmodule

bind errcap_unit errcap_chk #(.N(N), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .err_vld   (err_vld),
    .err_cls   (err_cls),
    .clr_we    (clr_we),
    .clr_mask  (clr_mask),
    .cap_valid (cap_valid),
    .cap_idx   (cap_idx),
    .cap_cls   (cap_cls),
    .cap_addr  (cap_addr),
    .cap_syn   (cap_syn)
);

// File: tb/sim_errcap_unit.sv
`timescale 1ns/1ps
module sim_errcap_unit;

    localparam int N  = 16;
    localparam int AW = 40;
    localparam int IW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  err_vld = '0;
    logic [2*N-1:0] err_cls = '0;
    logic [AW-1:0] err_addr = '0;
    logic [3:0]    err_tsyn = '0;
    logic [8:0]    err_dsyn = '0;
    logic          clr_we = 1'b0;
    logic [N-1:0]  clr_mask = '0;
    logic          cap_valid;
    logic [IW-1:0] cap_idx;
    logic [1:0]    cap_cls;
    logic [AW-1:0] cap_addr;
    logic [19:0]   cap_syn;

    int checks = 0;
    int fails  = 0;

    // Reference model state
    logic          m_valid = 1'b0;
    logic [IW-1:0] m_idx   = '0;
    logic [1:0]    m_cls   = '0;
    logic [AW-1:0] m_addr  = '0;
    logic [3:0]    m_tsyn  = '0;
    logic [8:0]    m_dsyn  = '0;

    errcap_unit #(.N(N), .ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .err_vld(err_vld), .err_cls(err_cls),
        .err_addr(err_addr), .err_tsyn(err_tsyn), .err_dsyn(err_dsyn),
        .clr_we(clr_we), .clr_mask(clr_mask), .cap_valid(cap_valid),
        .cap_idx(cap_idx), .cap_cls(cap_cls), .cap_addr(cap_addr), .cap_syn(cap_syn)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        chk(tag, "valid", 64'(cap_valid), 64'(m_valid));
        chk(tag, "idx",   64'(cap_idx),   64'(m_idx));
        chk(tag, "cls",   64'(cap_cls),   64'(m_cls));
        chk(tag, "addr",  64'(cap_addr),  64'(m_addr));
        chk({tag, " R9"}, "syn", 64'(cap_syn), 64'({m_tsyn, 7'b0, m_dsyn}));
    endtask

    // Model update from the inputs currently driven; returns a case tag
    function automatic string model_step();
        logic          own, any;
        logic [IW-1:0] w_idx;
        logic [1:0]    w_cls;
        int            cnt;
        string         t;
        own = m_valid && clr_we && clr_mask[m_idx];
        any = 1'b0; w_idx = '0; w_cls = '0; cnt = 0;
        for (int i = 0; i < N; i++) begin
            if (err_vld[i]) begin
                cnt++;
                if (!any || err_cls[2*i +: 2] > w_cls) begin
                    any = 1'b1; w_idx = IW'(i); w_cls = err_cls[2*i +: 2];
                end
            end
        end
        if (!m_valid || own) begin
            if (any) t = own ? "R8" : ((cnt > 1) ? "R3" : "R2");
            else if (own) begin t = "R6"; m_valid = 1'b0; end
            else t = "R7";
        end else if (any && w_cls > m_cls) begin
            t = (cnt > 1) ? "R3 R4" : "R4";
        end else begin
            any = 1'b0;
            t = (!clr_we && (clr_mask[m_idx])) ? "R10" : (clr_we ? "R6" : "R5");
        end
        if (any) begin
            m_valid = 1'b1; m_idx = w_idx; m_cls = w_cls;
            m_addr = err_addr; m_tsyn = err_tsyn; m_dsyn = err_dsyn;
        end
        return t;
    endfunction

    task automatic step(input string tag);
        string t;
        t = model_step();
        @(negedge clk);
        check_all((tag.len() > 0) ? tag : t);
    endtask

    task automatic put_ev(input int idx, input logic [1:0] c);
        err_vld[idx] = 1'b1;
        err_cls[2*idx +: 2] = c;
    endtask

    task automatic quiet();
        err_vld = '0; err_cls = '0; clr_we = 1'b0; clr_mask = '0;
        err_addr = {$urandom, $urandom};
        err_tsyn = 4'($urandom); err_dsyn = 9'($urandom);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd7411));
        repeat (3) @(negedge clk);
        check_all("R1 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1 after reset");

        // Directed corner cases
        quiet(); put_ev(5, 2'd1); err_addr = 40'h12_3456_7890; err_tsyn = 4'hA; err_dsyn = 9'h1C5;
        step("R2 first capture");
        quiet(); put_ev(2, 2'd0); step("R5 lower class ignored");
        quiet(); put_ev(0, 2'd1); step("R5 equal class ignored");
        quiet(); put_ev(9, 2'd3); put_ev(4, 2'd3); put_ev(1, 2'd2);
        step("R3 R4 tie to lowest index");
        chk("R3 winner", "idx", 64'(cap_idx), 64'd4);
        quiet(); clr_mask = '1; step("R10 mask without strobe");
        quiet(); clr_we = 1'b1; clr_mask = ~(16'h1 << 4); step("R6 other bits cleared");
        quiet(); clr_we = 1'b1; clr_mask = 16'h1 << 4; step("R6 owner cleared");
        quiet(); step("R7 retained");
        quiet(); step("R7 retained again");
        quiet(); put_ev(7, 2'd0); step("R2 recapture");
        quiet(); put_ev(3, 2'd0); clr_we = 1'b1; clr_mask = 16'h1 << 7; step("R8 clear with event");

        // Constrained random traffic
        for (int n = 0; n < 6000; n++) begin
            quiet();
            if ($urandom % 2 == 0) begin
                for (int k = 0; k < 1 + int'($urandom % 3); k++)
                    put_ev(int'($urandom % N), 2'($urandom));
            end
            case ($urandom % 6)
                0: begin clr_we = 1'b1; clr_mask = 16'($urandom); end
                1: begin clr_we = 1'b1; clr_mask = (16'h1 << m_idx) | (16'($urandom) & 16'($urandom)); end
                2: begin clr_we = 1'b0; clr_mask = 16'h1 << m_idx; end
                default: ;
            endcase
            step("");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule